// File: doc/BRIEF.md
# Multiply-Accumulate Dot Product Engine

This block is a command-driven integer multiply-accumulate unit. It holds a 48-bit accumulator and feeds it from a signed 24 by 24 multiplier. A controller issues one command at a time on the command port. Clear, the two loads and the two stores finish on the accepting edge. The single multiply-accumulate step and the three-pair dot product run for a fixed number of clock edges.

During a multi-cycle command the engine asks for operand pairs on a separate valid/ready operand port, one pair per two-cycle step. Every command that produces a result raises a one-cycle done pulse together with the result word. Arithmetic is two's complement and wraps modulo 2^48. There is no saturation and no floating-point handling.

Opcodes on `cmd_op` are: 0 clear, 1 load 32-bit, 2 load 48-bit, 3 store 32-bit, 4 store 48-bit, 5 multiply-accumulate, 6 dot product, 7 no operation.

Top module: `mac_dot_engine`

## Requirements
- R1: After reset the accumulator is zero, `cmd_ready` is 1, `opd_ready` is 0 and `res_valid` is 0.
- R2: Clear (opcode 0) sets the accumulator to zero on the accepting edge, and `res_valid` is high in the next cycle with `res_data` equal to 0.
- R3: Load 32-bit (opcode 1) writes `cmd_data[31:0]` into the accumulator, sign-extended from bit 31; `cmd_data[47:32]` is ignored. Load 48-bit (opcode 2) writes all of `cmd_data`. In both cases `res_data` returns the new accumulator value with the done pulse on the accepting edge.
- R4: Store 32-bit (opcode 3) returns the accumulator's low 32 bits in `res_data[31:0]` with `res_data[47:32]` zero. Store 48-bit (opcode 4) returns the whole accumulator. Neither store changes the accumulator, and both pulse done on the accepting edge.
- R5: Multiply-accumulate (opcode 5) takes one pair, `opd_a` and `opd_b`, each read as a signed 24-bit value. It adds their product to the accumulator modulo 2^48. With no operand stall, done rises on the 8th edge after the accepting edge, and `res_data` is the new 48-bit accumulator.
- R6: Dot product (opcode 6) clears the accumulator and then adds the products of three pairs. Each pair is read as signed 16-bit values from bits [15:0] of `opd_a` and `opd_b`; bits [23:16] are ignored. With no operand stall, done rises on the 6th edge after the accepting edge. `res_data` then carries the low 32 bits of the sum with bits [47:32] zero, and the accumulator keeps the 48-bit sum.
- R7: Each step takes two cycles: `opd_ready` is 0 in the cycle that follows an accepted operand pair.
- R8: From the acceptance of a multi-cycle command until its done pulse, `cmd_ready` is 0 and any offered command has no effect.
- R9: While the engine waits for an operand pair that is not offered, it does not advance. Each such cycle adds exactly one cycle to the latency and leaves the result unchanged.
- R10: Opcode 7 is accepted but produces no done pulse and leaves the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 48 | Load value |
| opd_valid | input | 1 | Operand pair offered |
| opd_ready | output | 1 | Engine wants an operand pair |
| opd_a | input | 24 | First operand |
| opd_b | input | 24 | Second operand |
| res_valid | output | 1 | One-cycle done pulse |
| res_data | output | 48 | Result word |

## Verification
The hardest situation to reach from the ports is an operand stall in the middle of a sequence, combined with a foreign command offered while the engine is busy. Both have to coincide with the exact edge on which the last add and the done pulse land. The stimulus table holds back operand pairs for a chosen number of ready cycles, so the latency stretch can be measured directly. A directed run keeps a clear command offered for the whole dot product, then reads the accumulator back to show that the clear was refused. The 48-bit wrap is reached by loading the largest positive value and adding a product of one.

// File: rtl/mac_dot_engine.sv
module mac_dot_engine #(
  parameter int OPW       = 24,
  parameter int ACCW      = 48,
  parameter int SHW       = 16,
  parameter int RESW      = 32,
  parameter int DOT_PAIRS = 3,
  parameter int DOT_CYC   = 6,
  parameter int MAC_CYC   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [ACCW-1:0] cmd_data,
  input  logic            opd_valid,
  output logic            opd_ready,
  input  logic [OPW-1:0]  opd_a,
  input  logic [OPW-1:0]  opd_b,
  output logic            res_valid,
  output logic [ACCW-1:0] res_data
);
  localparam int CW = $clog2(MAC_CYC + 1);
  localparam int PW = $clog2(DOT_PAIRS + 1);
  localparam logic [2:0] OP_CLR = 3'd0, OP_LD32 = 3'd1, OP_LD48 = 3'd2,
                         OP_ST32 = 3'd3, OP_ST48 = 3'd4, OP_MAC = 3'd5,
                         OP_DOT = 3'd6;

  logic [ACCW-1:0] acc, prod;
  logic            busy, ph, is_dot;
  logic [CW-1:0]   cnt;
  logic [PW-1:0]   left;

  wire take     = cmd_valid && cmd_ready;
  wire opd_take = opd_valid && opd_ready;
  assign cmd_ready = !busy;
  assign opd_ready = busy && !ph && (left != '0);

  wire signed [OPW-1:0] ma = is_dot ? {{(OPW-SHW){opd_a[SHW-1]}}, opd_a[SHW-1:0]} : opd_a;
  wire signed [OPW-1:0] mb = is_dot ? {{(OPW-SHW){opd_b[SHW-1]}}, opd_b[SHW-1:0]} : opd_b;
  wire signed [ACCW-1:0] mul = ma * mb;

  wire [ACCW-1:0] acc_sum  = acc + prod;
  wire            step_add = busy && ph;
  wire [CW-1:0]   cnt_nx   = cnt + 1'b1;
  wire            adv      = opd_take || step_add || (busy && left == '0);
  wire [CW-1:0]   lat      = is_dot ? CW'(DOT_CYC) : CW'(MAC_CYC);
  wire            fin      = adv && (cnt_nx == lat);
  wire [ACCW-1:0] fin_val  = step_add ? acc_sum : acc;
  wire [ACCW-1:0] ld32_val = {{(ACCW-RESW){cmd_data[RESW-1]}}, cmd_data[RESW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0; prod <= '0; busy <= 1'b0; ph <= 1'b0; is_dot <= 1'b0;
      cnt <= '0; left <= '0; res_valid <= 1'b0; res_data <= '0;
    end else begin
      res_valid <= 1'b0;
      if (take) begin
        case (cmd_op)
          OP_CLR:  begin acc <= '0; res_data <= '0; res_valid <= 1'b1; end
          OP_LD32: begin acc <= ld32_val; res_data <= ld32_val; res_valid <= 1'b1; end
          OP_LD48: begin acc <= cmd_data; res_data <= cmd_data; res_valid <= 1'b1; end
          OP_ST32: begin res_data <= {{(ACCW-RESW){1'b0}}, acc[RESW-1:0]}; res_valid <= 1'b1; end
          OP_ST48: begin res_data <= acc; res_valid <= 1'b1; end
          OP_MAC:  begin busy <= 1'b1; is_dot <= 1'b0; left <= PW'(1); cnt <= '0; ph <= 1'b0; end
          OP_DOT:  begin busy <= 1'b1; is_dot <= 1'b1; left <= PW'(DOT_PAIRS); cnt <= '0;
                         ph <= 1'b0; acc <= '0; end
          default: ;
        endcase
      end
      if (opd_take) begin
        prod <= mul;
        ph   <= 1'b1;
      end
      if (step_add) begin
        acc  <= acc_sum;
        ph   <= 1'b0;
        left <= left - 1'b1;
      end
      if (adv) cnt <= cnt_nx;
      if (fin) begin
        busy      <= 1'b0;
        res_valid <= 1'b1;
        res_data  <= is_dot ? {{(ACCW-RESW){1'b0}}, fin_val[RESW-1:0]} : fin_val;
      end
    end
  end

  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_op == OP_CLR |=> acc == '0 && res_valid && res_data == '0);

  assert_load_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_op == OP_LD32 |=>
      acc == {{(ACCW-RESW){$past(cmd_data[RESW-1])}}, $past(cmd_data[RESW-1:0])});

  assert_store_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_op == OP_ST48 |=> res_valid && res_data == $past(acc) && $stable(acc));

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < CW'(MAC_CYC));

  assert_step_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
    opd_take |=> !opd_ready);

  assert_busy_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take && (cmd_op == OP_MAC || cmd_op == OP_DOT) |=> !cmd_ready && !res_valid);

  assert_nop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_op == 3'd7 |=> !res_valid && $stable(acc));
endmodule

// File: tb/mac_dot_engine_tb_top.sv
module mac_dot_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cmd_valid = 1'b0, opd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [47:0] cmd_data = '0;
  logic [23:0] opd_a = '0, opd_b = '0;
  logic        cmd_ready, opd_ready, res_valid;
  logic [47:0] res_data;

  mac_dot_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .opd_valid(opd_valid), .opd_ready(opd_ready),
    .opd_a(opd_a), .opd_b(opd_b), .res_valid(res_valid), .res_data(res_data));

  int checks = 0, fails = 0;
  logic [47:0] m_acc = '0;

  localparam int NV = 13;
  localparam logic [2:0]  V_OP [NV] = '{3'd2, 3'd5, 3'd4, 3'd1, 3'd3, 3'd5, 3'd6, 3'd4,
                                         3'd6, 3'd4, 3'd5, 3'd0, 3'd4};
  localparam logic [47:0] V_D  [NV] = '{48'h7FFF_FFFF_FFFF, 0, 0, 48'h1234_8000_0001, 0, 0,
                                         0, 0, 0, 0, 0, 0, 0};
  localparam logic [71:0] V_A  [NV] = '{0, 72'h1, 0, 0, 0, 72'hFFFFFD,
                                         {24'hAB0064, 24'hCDFFFE, 24'h127FFF}, 0,
                                         {24'h008000, 24'h008000, 24'h008000}, 0, 72'h800000, 0, 0};
  localparam logic [71:0] V_B  [NV] = '{0, 72'h1, 0, 0, 0, 72'h000005,
                                         {24'h00FF9C, 24'h990003, 24'hEE7FFF}, 0,
                                         {24'h008000, 24'h008000, 24'h008000}, 0, 72'h800000, 0, 0};
  localparam int V_ST [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 2, 0, 1, 0, 0};

  task automatic chk(input logic [47:0] act, input logic [47:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic logic [47:0] sx24(input logic [23:0] v); return {{24{v[23]}}, v}; endfunction
  function automatic logic [47:0] sx16(input logic [15:0] v); return {{32{v[15]}}, v}; endfunction

  function automatic string tag(input logic [2:0] op, input int stall);
    string s;
    case (op)
      3'd0: s = "R2 clear";
      3'd1, 3'd2: s = "R3 load";
      3'd3, 3'd4: s = "R4 store";
      3'd5: s = "R5 mac";
      3'd6: s = "R6 dot";
      default: s = "R10 nop";
    endcase
    if (stall > 0) s = {s, " R9 stall"};
    return s;
  endfunction

  task automatic model(input logic [2:0] op, input logic [47:0] d,
                       input logic [71:0] av, input logic [71:0] bv, output logic [47:0] r);
    case (op)
      3'd0: begin m_acc = '0; r = '0; end
      3'd1: begin m_acc = {{16{d[31]}}, d[31:0]}; r = m_acc; end
      3'd2: begin m_acc = d; r = d; end
      3'd3: r = {16'h0, m_acc[31:0]};
      3'd4: r = m_acc;
      3'd5: begin m_acc = m_acc + sx24(av[23:0]) * sx24(bv[23:0]); r = m_acc; end
      3'd6: begin
        m_acc = '0;
        for (int i = 0; i < 3; i++) m_acc = m_acc + sx16(av[i*24 +: 16]) * sx16(bv[i*24 +: 16]);
        r = {16'h0, m_acc[31:0]};
      end
      default: r = '0;
    endcase
  endtask

  task automatic run(input logic [2:0] op, input logic [47:0] d, input logic [71:0] av,
                     input logic [71:0] bv, input int stall, input bit intr);
    int edges = 0, idx = 0, sl = stall, lat;
    bit saw_ready = 0;
    logic [47:0] exp;
    string t = tag(op, stall);
    lat = (op == 3'd5) ? 8 : (op == 3'd6) ? 6 : 0;
    model(op, d, av, bv, exp);
    @(negedge clk);
    chk({47'h0, cmd_ready}, 48'h1, {t, " R8 ready before command"});
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!res_valid && edges < 40) begin
      if (intr) begin
        cmd_valid = 1'b1; cmd_op = 3'd0;
        if (cmd_ready) saw_ready = 1;
      end
      opd_valid = 1'b0;
      if (opd_ready && idx < 3) begin
        if (sl > 0) sl--;
        else begin
          opd_valid = 1'b1; opd_a = av[idx*24 +: 24]; opd_b = bv[idx*24 +: 24];
        end
      end
      @(posedge clk);
      if (opd_valid) begin
        idx++;
        @(negedge clk);
        if (opd_ready) chk({47'h0, opd_ready}, 48'h0, "R7 ready low after pair");
      end else @(negedge clk);
      edges++;
      opd_valid = 1'b0;
    end
    cmd_valid = 1'b0;
    if (intr) chk({47'h0, saw_ready}, 48'h0, "R8 cmd_ready while busy");
    chk(48'(edges), 48'(lat + stall), {t, " latency"});
    chk(res_data, exp, {t, " result"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [47:0] tmp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk({47'h0, cmd_ready}, 48'h1, "R1 cmd_ready after reset");
    chk({47'h0, opd_ready}, 48'h0, "R1 opd_ready after reset");
    chk({47'h0, res_valid}, 48'h0, "R1 res_valid after reset");
    run(3'd4, 0, 0, 0, 0, 0);

    for (int v = 0; v < NV; v++) run(V_OP[v], V_D[v], V_A[v], V_B[v], V_ST[v], 0);

    run(3'd2, 48'h5A5A_1234_ABCD, 0, 0, 0, 0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd7; cmd_data = 48'h0;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk({47'h0, res_valid}, 48'h0, "R10 no done for opcode 7");
      @(negedge clk);
    end
    run(3'd4, 0, 0, 0, 0, 0);

    run(3'd6, 0, {24'h000003, 24'h000002, 24'h000001},
        {24'h000007, 24'h000006, 24'h000005}, 1, 1);
    run(3'd4, 0, 0, 0, 0, 0);
    run(3'd3, 0, 0, 0, 0, 0);

    run(3'd2, 48'hFFFF_FFFF_FFFF, 0, 0, 0, 0);
    run(3'd5, 0, 72'h7FFFFF, 72'h7FFFFF, 3, 0);
    model(3'd4, 0, 0, 0, tmp);
    run(3'd4, 0, 0, 0, 0, 0);
    summary();
  end
endmodule